// File: doc/BRIEF.md
# Condition Code Flag Register

This block holds the eight-bit condition code register of an 8-bit accumulator processor. It computes the arithmetic flags (carry C, overflow V, zero Z, negative N and half-carry H). It also keeps the two interrupt masks, I and X. Each cycle the datapath presents an operation class code, the two ALU operands, the ALU result and, for index operations, the 16-bit index result. When the flag-write strobe is high, the block updates only the flags that the operation class defines.

The mask bits follow their own sequence. Reset sets both masks. The interrupt sequencer pulses an accept input once the registers are stacked and before the vector fetch; this sets I, and it also sets X when the source is the non-maskable pin. A return-from-interrupt strobe loads the whole register from the unstacked byte. Software may set or clear I, and may clear X, but has no way to set X.

Top module: `ccr_unit`

## Requirements
- R1: After reset the register reads 0xD0. Bit positions are C=0, V=1, Z=2, N=3, I=4, H=5, X=6, S=7, where S is a stored bit that only reset and restore write. I, X and S come out of reset set; the other bits come out clear.
- R2: Class codes for op_i are: 0 none, 1 ADD, 2 ADC, 3 SUB, 4 SBC, 5 CMP, 6 LOGIC, 7 MOVE, 8 SHL, 9 SHR, 10 IDX. Codes 0 and 11 to 15 update no flag.
- R3: ADD and ADC set C on an unsigned carry out of the MSB, set V on signed overflow, and set H on a carry from bit 3 into bit 4. These two classes are the only ones that change H.
- R4: SUB, SBC and CMP set C when a borrow occurs. They set V when the operand signs differ and the sign of the result differs from the sign of the minuend. H is left unchanged.
- R5: Every class except IDX and the no-update codes sets Z when the 8-bit result is zero and sets N to the MSB of that result.
- R6: LOGIC and MOVE clear V and leave C and H unchanged.
- R7: SHL loads C from the operand MSB, and SHR loads C from operand bit 0. In both cases V becomes N XOR C.
- R8: IDX sets Z only if the 16-bit index result is zero. Every other bit is left unchanged.
- R9: When flag_we_i is low, the arithmetic flags keep their value.
- R10: An interrupt accept sets I on the next edge. It also sets X when irq_xsrc_i is high. It touches no arithmetic flag.
- R11: A restore strobe loads all eight bits from rti_data_i. A restore that arrives in the same cycle as an accept is ignored.
- R12: sw_sei_i sets I, sw_cli_i clears I and sw_clx_i clears X. No software input sets X.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation class code |
| opa_i | input | 8 | First ALU operand (minuend for subtract) |
| opb_i | input | 8 | Second ALU operand |
| res_i | input | 8 | ALU result |
| idx_res_i | input | 16 | Index register result |
| flag_we_i | input | 1 | Flag-write strobe |
| irq_accept_i | input | 1 | Interrupt accepted, registers already stacked |
| irq_xsrc_i | input | 1 | The accepted interrupt came from the non-maskable pin |
| rti_load_i | input | 1 | Restore strobe |
| rti_data_i | input | 8 | Unstacked register value |
| sw_sei_i | input | 1 | Software set of I |
| sw_cli_i | input | 1 | Software clear of I |
| sw_clx_i | input | 1 | Software clear of X |
| ccr_o | output | 8 | Condition code register |

## Verification
The hardest state to reach from the ports is one where a flag a class must not touch holds a value that a wrong update would visibly change. An example is H left set from an earlier add when a subtract, shift or index operation runs, or N left clear while an index operation presents a result with its MSB set. The directed sequence builds up that state on purpose before each class is tested. A restore that collides with an accept is driven with data that differs from the current masks, so any leak from the restore shows at the port.

// File: rtl/ccr_pkg.sv
`timescale 1ns/1ps
package ccr_pkg;
  localparam int unsigned CCR_W  = 8;
  localparam int unsigned OP_W   = 4;
  localparam int unsigned C_POS  = 0;
  localparam int unsigned V_POS  = 1;
  localparam int unsigned Z_POS  = 2;
  localparam int unsigned N_POS  = 3;
  localparam int unsigned I_POS  = 4;
  localparam int unsigned H_POS  = 5;
  localparam int unsigned X_POS  = 6;
  localparam int unsigned S_POS  = 7;
  localparam logic [CCR_W-1:0] CCR_RST = 8'hD0;

  typedef enum logic [OP_W-1:0] {
    OP_NONE  = 4'd0,
    OP_ADD   = 4'd1,
    OP_ADC   = 4'd2,
    OP_SUB   = 4'd3,
    OP_SBC   = 4'd4,
    OP_CMP   = 4'd5,
    OP_LOGIC = 4'd6,
    OP_MOVE  = 4'd7,
    OP_SHL   = 4'd8,
    OP_SHR   = 4'd9,
    OP_IDX   = 4'd10
  } op_cls_e;
endpackage

// File: rtl/ccr_flag_calc.sv
`timescale 1ns/1ps
module ccr_flag_calc
  import ccr_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = 16
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic [IDX_W-1:0]  idx_res_i,
  output logic [CCR_W-1:0]  upd_o,
  output logic [CCR_W-1:0]  val_o
);
  localparam int unsigned MSB = DATA_W - 1;

  logic a_m, b_m, r_m, a_h, b_h, r_h;
  logic add_c, add_v, add_h, sub_c, sub_v, sh_c;

  assign a_m = opa_i[MSB];
  assign b_m = opb_i[MSB];
  assign r_m = res_i[MSB];
  assign a_h = opa_i[3];
  assign b_h = opb_i[3];
  assign r_h = res_i[3];

  // carry/borrow recovered from operand and result sign bits
  assign add_c = (a_m & b_m) | (b_m & ~r_m) | (~r_m & a_m);
  assign add_v = (a_m & b_m & ~r_m) | (~a_m & ~b_m & r_m);
  assign add_h = (a_h & b_h) | (b_h & ~r_h) | (~r_h & a_h);
  assign sub_c = (~a_m & b_m) | (b_m & r_m) | (r_m & ~a_m);
  assign sub_v = (a_m & ~b_m & ~r_m) | (~a_m & b_m & r_m);
  assign sh_c  = (op_i == OP_SHL) ? a_m : opa_i[0];

  always_comb begin
    upd_o        = '0;
    val_o        = '0;
    val_o[Z_POS] = ~|res_i;
    val_o[N_POS] = r_m;
    unique case (op_i)
      OP_ADD, OP_ADC: begin
        upd_o[C_POS] = 1'b1; upd_o[V_POS] = 1'b1; upd_o[H_POS] = 1'b1;
        upd_o[Z_POS] = 1'b1; upd_o[N_POS] = 1'b1;
        val_o[C_POS] = add_c; val_o[V_POS] = add_v; val_o[H_POS] = add_h;
      end
      OP_SUB, OP_SBC, OP_CMP: begin
        upd_o[C_POS] = 1'b1; upd_o[V_POS] = 1'b1;
        upd_o[Z_POS] = 1'b1; upd_o[N_POS] = 1'b1;
        val_o[C_POS] = sub_c; val_o[V_POS] = sub_v;
      end
      OP_LOGIC, OP_MOVE: begin
        upd_o[V_POS] = 1'b1; upd_o[Z_POS] = 1'b1; upd_o[N_POS] = 1'b1;
      end
      OP_SHL, OP_SHR: begin
        upd_o[C_POS] = 1'b1; upd_o[V_POS] = 1'b1;
        upd_o[Z_POS] = 1'b1; upd_o[N_POS] = 1'b1;
        val_o[C_POS] = sh_c; val_o[V_POS] = r_m ^ sh_c;
      end
      OP_IDX: begin
        upd_o[Z_POS] = 1'b1;
        val_o[Z_POS] = ~|idx_res_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ccr_mask_ctrl.sv
`timescale 1ns/1ps
module ccr_mask_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_accept_i,
  input  logic irq_xsrc_i,
  input  logic rti_load_i,
  input  logic rti_i_i,
  input  logic rti_x_i,
  input  logic sw_sei_i,
  input  logic sw_cli_i,
  input  logic sw_clx_i,
  output logic i_o,
  output logic x_o
);
  logic i_q, x_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      i_q <= 1'b1;
      x_q <= 1'b1;
    end else if (irq_accept_i) begin
      i_q <= 1'b1;
      x_q <= x_q | irq_xsrc_i;
    end else if (rti_load_i) begin
      i_q <= rti_i_i;
      x_q <= rti_x_i;
    end else begin
      if (sw_sei_i)      i_q <= 1'b1;
      else if (sw_cli_i) i_q <= 1'b0;
      if (sw_clx_i)      x_q <= 1'b0;
    end
  end

  assign i_o = i_q;
  assign x_o = x_q;

  // R10
  irq_sets_i_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_accept_i |=> i_q);
  // R10
  irq_sets_x_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_accept_i && irq_xsrc_i) |=> x_q);
  // R12
  x_no_sw_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(x_q) |-> $past((irq_accept_i && irq_xsrc_i) || rti_load_i));
endmodule

// File: rtl/ccr_unit.sv
`timescale 1ns/1ps
module ccr_unit
  import ccr_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic [IDX_W-1:0]  idx_res_i,
  input  logic              flag_we_i,
  input  logic              irq_accept_i,
  input  logic              irq_xsrc_i,
  input  logic              rti_load_i,
  input  logic [CCR_W-1:0]  rti_data_i,
  input  logic              sw_sei_i,
  input  logic              sw_cli_i,
  input  logic              sw_clx_i,
  output logic [CCR_W-1:0]  ccr_o
);
  logic [CCR_W-1:0] upd, val, ccr;
  logic rti_eff, i_bit, x_bit;

  assign rti_eff = rti_load_i & ~irq_accept_i;

  ccr_flag_calc #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_calc (
    .op_i      (op_i),
    .opa_i     (opa_i),
    .opb_i     (opb_i),
    .res_i     (res_i),
    .idx_res_i (idx_res_i),
    .upd_o     (upd),
    .val_o     (val)
  );

  ccr_mask_ctrl i_mask (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .irq_accept_i (irq_accept_i),
    .irq_xsrc_i   (irq_xsrc_i),
    .rti_load_i   (rti_load_i),
    .rti_i_i      (rti_data_i[I_POS]),
    .rti_x_i      (rti_data_i[X_POS]),
    .sw_sei_i     (sw_sei_i),
    .sw_cli_i     (sw_cli_i),
    .sw_clx_i     (sw_clx_i),
    .i_o          (i_bit),
    .x_o          (x_bit)
  );

  for (genvar k = 0; k < CCR_W; k++) begin : g_bit
    if (k == I_POS) begin : g_i
      assign ccr[k] = i_bit;
    end else if (k == X_POS) begin : g_x
      assign ccr[k] = x_bit;
    end else begin : g_ff
      logic bit_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                    bit_q <= CCR_RST[k];
        else if (rti_eff)               bit_q <= rti_data_i[k];
        else if (flag_we_i && upd[k])   bit_q <= val[k];
      end
      assign ccr[k] = bit_q;
    end
  end

  assign ccr_o = ccr;

  // R9
  hold_no_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_we_i && !rti_load_i) |=>
      $stable({ccr_o[H_POS], ccr_o[N_POS], ccr_o[Z_POS], ccr_o[V_POS], ccr_o[C_POS]}));
  // R8
  idx_only_z_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && op_i == OP_IDX && !rti_load_i) |=>
      $stable({ccr_o[H_POS], ccr_o[N_POS], ccr_o[V_POS], ccr_o[C_POS]}));
  // R6
  logic_v_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && (op_i == OP_LOGIC || op_i == OP_MOVE) && !rti_load_i) |=>
      !ccr_o[V_POS]);
  // R11
  rti_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rti_load_i && !irq_accept_i) |=> ccr_o == $past(rti_data_i));
  // R10
  irq_keeps_arith_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_accept_i && !flag_we_i) |=>
      $stable({ccr_o[H_POS], ccr_o[N_POS], ccr_o[Z_POS], ccr_o[V_POS], ccr_o[C_POS]}));
endmodule

// File: tb/test_ccr_unit.sv
`timescale 1ns/1ps
module test_ccr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op = '0;
  logic [7:0]  opa = '0, opb = '0, res = '0, rti_data = '0;
  logic [15:0] idx_res = '0;
  logic        we = 0, irq = 0, xsrc = 0, rti = 0, sei = 0, cli = 0, clx = 0;
  logic [7:0]  ccr;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  ccr_unit i_ccr_unit (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .opa_i(opa), .opb_i(opb),
    .res_i(res), .idx_res_i(idx_res), .flag_we_i(we), .irq_accept_i(irq),
    .irq_xsrc_i(xsrc), .rti_load_i(rti), .rti_data_i(rti_data),
    .sw_sei_i(sei), .sw_cli_i(cli), .sw_clx_i(clx), .ccr_o(ccr)
  );

  task automatic check(string req, logic [7:0] exp);
    n_chk++;
    if (ccr !== exp) begin
      n_fail++;
      $display("FAIL %s: ccr=%h expected %h", req, ccr, exp);
    end
  endtask

  task automatic idle();
    op = 0; we = 0; irq = 0; xsrc = 0; rti = 0; sei = 0; cli = 0; clx = 0;
  endtask

  // one clock with current inputs, sample at following negedge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic alu(logic [3:0] o, logic [7:0] a, logic [7:0] b, logic [7:0] r,
                     logic w, string req, logic [7:0] exp);
    op = o; opa = a; opb = b; res = r; we = w;
    tick();
    check(req, exp);
  endtask

  task automatic t_reset();
    check("R1 reset", 8'hD0);
    cli = 1; tick(); check("R12 cli", 8'hC0);
    clx = 1; tick(); check("R12 clx", 8'h80);
  endtask

  task automatic t_add();
    alu(4'd1, 8'h7F, 8'h01, 8'h80, 1, "R3 add ovf", 8'hAA);
    alu(4'd1, 8'hFF, 8'h01, 8'h00, 1, "R3 R5 add carry zero", 8'hA5);
    alu(4'd2, 8'h08, 8'h07, 8'h10, 1, "R3 adc half", 8'hA0);
  endtask

  task automatic t_sub();
    alu(4'd3, 8'h10, 8'h20, 8'hF0, 1, "R4 sub borrow", 8'hA9);
    alu(4'd6, 8'h0F, 8'hF0, 8'h00, 1, "R6 logic", 8'hA5);
    alu(4'd5, 8'h80, 8'h01, 8'h7F, 1, "R4 cmp ovf", 8'hA2);
  endtask

  task automatic t_idx();
    idx_res = 16'h0000;
    alu(4'd10, 8'hFF, 8'h01, 8'h80, 1, "R8 idx zero", 8'hA6);
    idx_res = 16'h0100;
    alu(4'd10, 8'h00, 8'h00, 8'h00, 1, "R8 idx nonzero", 8'hA2);
  endtask

  task automatic t_shift();
    alu(4'd8, 8'h81, 8'h00, 8'h02, 1, "R7 shl", 8'hA3);
    alu(4'd9, 8'h01, 8'h00, 8'h00, 1, "R7 shr", 8'hA7);
  endtask

  task automatic t_gate();
    alu(4'd1, 8'h7F, 8'h01, 8'h80, 0, "R9 no strobe", 8'hA7);
    alu(4'd12, 8'h7F, 8'h01, 8'h80, 1, "R2 unused code", 8'hA7);
    alu(4'd7, 8'h00, 8'h00, 8'h80, 1, "R5 R6 move", 8'hA9);
  endtask

  task automatic t_irq();
    irq = 1; tick(); check("R10 accept I", 8'hB9);
    rti = 1; rti_data = 8'h2A; tick(); check("R11 restore", 8'h2A);
    irq = 1; xsrc = 1; tick(); check("R10 accept X", 8'h7A);
    rti = 1; rti_data = 8'h00; tick(); check("R11 restore zero", 8'h00);
    irq = 1; rti = 1; rti_data = 8'hFF; tick(); check("R11 collide", 8'h10);
    cli = 1; tick(); check("R12 cli2", 8'h00);
    sei = 1; tick(); check("R12 sei", 8'h10);
  endtask

  task automatic t_reset_again();
    @(negedge clk); rst_n = 0;
    #1 check("R1 async reset", 8'hD0);
    @(negedge clk); rst_n = 1;
    tick(); check("R1 after release", 8'hD0);
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_add();
    t_sub();
    t_idx();
    t_shift();
    t_gate();
    t_irq();
    t_reset_again();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule